// File: doc/BRIEF.md
# Call-Waiting Caller-ID Handshake Sequencer

This block runs the off-hook half of a caller-identity-on-call-waiting exchange. It watches two outputs of an external tone-alert and FSK receiver: a level/tone detect line and an active-low interrupt. It also drives that receiver's mode select and the local mute controls.

While the receiver listens for the alert tone, the sequencer mutes the near-end microphone for as long as detect is high. This keeps local speech from imitating the tone. A low interrupt means an alert has qualified. The sequencer then mutes the handset and keypad and moves the receiver into FSK mode, which also clears the interrupt. After the switch it watches detect through a quiet guard window.

Activity during the guard window marks the alert as false. The sequencer drops the transaction and raises a one-cycle abandon flag. A quiet window instead leads to a one-cycle request for the acknowledge tone to be sent. The sequencer then waits for the FSK burst to start and end. A missing burst times out. Either way it unmutes and returns the receiver to tone-alert mode. Timing is set in milliseconds and scaled by the clock rate in kHz.

Top module: `cwcid_seq`

## Requirements
- R1: In tone-alert mode (`rx_fsk_mode` = 0), `mic_mute` equals the value `det` had at the previous clock edge, a latency of one cycle.
- R2: In tone-alert mode, `irq_n` sampled low makes `rx_fsk_mode`, `hset_mute` and `mic_mute` all 1 after that edge. In FSK mode (`rx_fsk_mode` = 1), `hset_mute` and `mic_mute` are 1.
- R3: `det` sampled high at any of the GUARD_MS*CLK_KHZ edges after the mode switch gives the following result after that edge: `abandon` = 1 for one cycle, `rx_fsk_mode` = 0 and `hset_mute` = 0. No `ack_req` pulse is issued.
- R4: `det` low through the whole guard window gives `ack_req` = 1 for exactly one cycle. The pulse starts after the GUARD_MS*CLK_KHZ-th edge following the edge that entered FSK mode.
- R5: The sequencer waits ACK_TMO_MS*CLK_KHZ edges after the pulse. If `det` stays low throughout, it returns to tone-alert mode and `abandon` stays 0. A `det` high on the last edge of the wait still counts as a started burst.
- R6: Once a burst has started, the sequencer returns to tone-alert mode after QUIET_MS*CLK_KHZ consecutive edges with `det` low. Any `det` high restarts that count.
- R7: After reset, `rx_fsk_mode`, `hset_mute`, `mic_mute`, `ack_req` and `abandon` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det | input | 1 | Receiver detect output (tone or FSK level) |
| irq_n | input | 1 | Receiver interrupt, active low (alert qualified) |
| rx_fsk_mode | output | 1 | Receiver mode select: 0 tone-alert, 1 FSK |
| mic_mute | output | 1 | Near-end microphone mute |
| hset_mute | output | 1 | Handset and keypad mute |
| ack_req | output | 1 | One-cycle request to send the acknowledge tone |
| abandon | output | 1 | One-cycle flag: transaction dropped as a false alert |

## Verification
A wrong sequencer state shows up on the mode and mute pins on the very next edge. The bench sweeps the edge at which detect rises across every cycle of the guard window and across the quiet count of the receive phase. A window counter that is off by one therefore moves the acknowledge pulse, the abandon flag or the return to tone-alert mode by one cycle, and the exact-cycle checks catch it. A mishandled timeout leaves the mode pin high one cycle too long or drops it one cycle early.

// File: rtl/cwcid_seq.sv
module cwcid_seq #(
  parameter int CLK_KHZ  = 1000,
  parameter int GUARD_MS = 50,
  parameter int ACK_TMO_MS = 500,
  parameter int QUIET_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic irq_n,
  output logic rx_fsk_mode,
  output logic mic_mute,
  output logic hset_mute,
  output logic ack_req,
  output logic abandon
);
  localparam int GUARD_CYC = GUARD_MS * CLK_KHZ;
  localparam int TMO_CYC   = ACK_TMO_MS * CLK_KHZ;
  localparam int QUIET_CYC = QUIET_MS * CLK_KHZ;
  localparam int MAX_CYC   = (TMO_CYC > GUARD_CYC) ?
                             ((TMO_CYC > QUIET_CYC) ? TMO_CYC : QUIET_CYC) :
                             ((GUARD_CYC > QUIET_CYC) ? GUARD_CYC : QUIET_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_TONE, S_GUARD, S_ACK, S_WAIT, S_RX} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          det_q;
  logic          abandon_q;

  wire at_guard_end = (cnt == CW'(GUARD_CYC - 1));
  wire at_tmo_end   = (cnt == CW'(TMO_CYC - 1));
  wire at_quiet_end = (cnt == CW'(QUIET_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_TONE;
      cnt       <= '0;
      det_q     <= 1'b0;
      abandon_q <= 1'b0;
    end else begin
      det_q     <= det;
      abandon_q <= 1'b0;
      case (st)
        S_TONE: begin
          cnt <= '0;
          if (!irq_n) st <= S_GUARD;
        end
        S_GUARD: begin
          if (det) begin
            st        <= S_TONE;
            abandon_q <= 1'b1;
            cnt       <= '0;
          end else if (at_guard_end) begin
            st  <= S_ACK;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ACK: begin
          st  <= S_WAIT;
          cnt <= '0;
        end
        S_WAIT: begin
          if (det) begin
            st  <= S_RX;
            cnt <= '0;
          end else if (at_tmo_end) begin
            st  <= S_TONE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RX: begin
          if (det) begin
            cnt <= '0;
          end else if (at_quiet_end) begin
            st  <= S_TONE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= S_TONE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign rx_fsk_mode = (st != S_TONE);
  assign hset_mute   = rx_fsk_mode;
  assign mic_mute    = rx_fsk_mode | det_q;
  assign ack_req     = (st == S_ACK);
  assign abandon     = abandon_q;

  // R1: in tone mode the mic mute tracks detect with one cycle of delay
  p_mic_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_fsk_mode && $past(rst_n)) |-> (mic_mute == $past(det)));

  // R2: qualified alert moves to FSK mode with all mutes set
  p_alert_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_fsk_mode && !irq_n) |=> (rx_fsk_mode && hset_mute && mic_mute));

  // R3: abandon only when leaving FSK mode, never together with ack
  p_abandon_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |-> (!rx_fsk_mode && !ack_req && $past(rx_fsk_mode)));

  // R4: acknowledge request is a single-cycle pulse issued in FSK mode
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> (!ack_req && rx_fsk_mode));

  // R4: no acknowledge after a detect seen in the guard window
  p_no_ack_on_det_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GUARD && det) |=> !ack_req);

  // R6: detect high while receiving keeps the receiver in FSK mode
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && det) |=> rx_fsk_mode);
endmodule

// File: tb/sim_cwcid_seq.sv
module sim_cwcid_seq;
  localparam int KHZ = 1, GMS = 12, TMS = 20, QMS = 9;
  localparam int G = GMS * KHZ, T = TMS * KHZ, Q = QMS * KHZ;

  logic clk = 1'b0, rst_n = 1'b0, det = 1'b0, irq_n = 1'b1;
  logic rx_fsk_mode, mic_mute, hset_mute, ack_req, abandon;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cwcid_seq #(.CLK_KHZ(KHZ), .GUARD_MS(GMS), .ACK_TMO_MS(TMS), .QUIET_MS(QMS)) u0 (
    .clk(clk), .rst_n(rst_n), .det(det), .irq_n(irq_n), .rx_fsk_mode(rx_fsk_mode),
    .mic_mute(mic_mute), .hset_mute(hset_mute), .ack_req(ack_req), .abandon(abandon));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Alert qualifies: irq low for one edge, check R2 state after it
  task automatic enter_fsk();
    irq_n = 1'b0; step(); irq_n = 1'b1;
    chk("R2 mode", rx_fsk_mode, 1'b1);
    chk("R2 hset", hset_mute, 1'b1);
    chk("R2 mic", mic_mute, 1'b1);
  endtask

  // Quiet guard, ack pulse on the G-th edge after entry
  task automatic pass_guard();
    for (int i = 1; i < G; i++) begin
      step(); chk("R4 no early ack", ack_req, 1'b0);
    end
    step(); chk("R4 ack", ack_req, 1'b1);
    step(); chk("R4 ack single", ack_req, 1'b0);
    chk("R4 still fsk", rx_fsk_mode, 1'b1);
  endtask

  initial begin
    step(); step();
    chk("R7 mode", rx_fsk_mode, 1'b0); chk("R7 mic", mic_mute, 1'b0);
    chk("R7 hset", hset_mute, 1'b0); chk("R7 ack", ack_req, 1'b0);
    chk("R7 abandon", abandon, 1'b0);
    rst_n = 1'b1; step();

    // R1: mic mute follows det with one cycle delay
    for (int p = 0; p < 8; p++) begin
      det = p[0] ^ p[2]; step();
      chk("R1 mic follow", mic_mute, p[0] ^ p[2]);
      chk("R1 stays tone", rx_fsk_mode, 1'b0);
    end
    det = 1'b0; step();

    // R3: sweep the guard cycle at which det rises
    for (int j = 0; j < G; j++) begin
      enter_fsk();
      for (int i = 0; i < j; i++) begin
        step(); chk("R3 no ack", ack_req, 1'b0);
      end
      det = 1'b1; step(); det = 1'b0;
      chk("R3 abandon", abandon, 1'b1);
      chk("R3 mode", rx_fsk_mode, 1'b0);
      chk("R3 hset", hset_mute, 1'b0);
      step();
      chk("R3 abandon single", abandon, 1'b0);
      chk("R3 no ack after", ack_req, 1'b0);
      step();
    end

    // R5: timeout with no burst
    enter_fsk(); pass_guard();
    for (int i = 1; i < T; i++) begin
      step(); chk("R5 waiting", rx_fsk_mode, 1'b1);
    end
    step(); chk("R5 timeout", rx_fsk_mode, 1'b0);
    chk("R5 no abandon", abandon, 1'b0);
    chk("R5 unmute", hset_mute, 1'b0);
    step();

    // R5: det on the last wait edge still starts the burst
    enter_fsk(); pass_guard();
    for (int i = 1; i < T; i++) step();
    det = 1'b1; step(); det = 1'b0;
    chk("R5 late burst", rx_fsk_mode, 1'b1);
    for (int i = 1; i < Q; i++) begin
      step(); chk("R6 quiet count", rx_fsk_mode, 1'b1);
    end
    step(); chk("R6 end", rx_fsk_mode, 1'b0);
    step();

    // R6: sweep the restart point inside the quiet count
    for (int k = 0; k < Q - 1; k++) begin
      enter_fsk(); pass_guard();
      step(); step();
      det = 1'b1; step(); step(); det = 1'b0;
      for (int i = 0; i < k; i++) begin
        step(); chk("R6 before glitch", rx_fsk_mode, 1'b1);
      end
      det = 1'b1; step(); det = 1'b0;
      for (int i = 1; i < Q; i++) begin
        step(); chk("R6 restart hold", rx_fsk_mode, 1'b1);
      end
      step();
      chk("R6 end after restart", rx_fsk_mode, 1'b0);
      chk("R6 unmute", hset_mute, 1'b0);
      step();
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule